// File: doc/BRIEF.md
# Interrupt Aggregator with Write-Message Delivery

The block gathers a set of level interrupt lines into two sticky registers, one that records every line seen high and one that records only the lines that software has enabled. It does not drive a wire to the processor. It tells the processor about an enabled interrupt by sending one 32-bit write on an outbound request port. The address and the payload of that write both come from a single programmable target register. The upper 27 bits, with the low five bits zeroed, form the address. The low five bits alone form the data word.

Software uses a small word-addressed register port with big-endian byte strobes. It reads and writes the enable mask, the control word and the target register. It reads the two interrupt registers. Reading or writing the seen-high register clears it. A control bit suppresses message delivery. Enabled events that arrive while the outbound port is stalled are each held as a flag for their source and are sent lowest source first.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset the request, mask, pending and control registers read 0, the target register reads 0xFFFB0003, msg_valid is 0 and mask_err is 0.
- R2: While input n is high, pending bit n is set. Request bit n is set only if mask bit n is also 1. Both bits stay set after the input falls.
- R3: A read of the pending register (word 2) returns its current contents and clears it to zero at that edge. A write to word 2 clears it whatever the data and strobes are. An input that is high in the clearing cycle stays recorded.
- R4: The request register (word 0) is read-only. A write to it leaves its contents unchanged.
- R5: A read of the control register (word 3) returns only bit 0, the delivery-suppress bit. All other bits read as 0.
- R6: A message has address = target with bits 4:0 forced to 0 and data = target bits 4:0 zero-extended. msg_valid stays high and msg_addr/msg_data stay stable until msg_ready is seen.
- R7: While control bit 0 is 1, enabled events are discarded and produce no message.
- R8: Each rising edge of (input n AND mask bit n) produces exactly one message. A line held high produces no further messages.
- R9: Events from several sources that wait for msg_ready are kept as one flag per source and sent one message per flag, lowest source first. A second edge from a source whose flag is still set merges into that flag.
- R10: A mask write (word 1) whose resulting value has a bit at or above NUM_SRC sets mask_err for one cycle after the write, unless the value is all ones. The value is stored in either case.
- R11: reg_be[0] enables bits 31:24, reg_be[1] bits 23:16, reg_be[2] bits 15:8 and reg_be[3] bits 7:0. Bytes that are not enabled keep their old value.
- R12: Words 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level interrupt lines |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Big-endian byte enables |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_re |
| mask_err | output | 1 | Invalid mask write flag, one cycle |
| msg_valid | output | 1 | Outbound write request valid |
| msg_ready | input | 1 | Outbound write request accepted |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |

## Verification
A wrong edge-history register shows up at msg_valid in the cycle after the input edge. It appears either as a message the scoreboard did not expect or as a queued message that never arrives. A flag that is lost or doubled while msg_ready is low changes the number of messages drained after ready returns, so the error is visible within a few cycles. A clear of the pending register at the wrong time, or a byte merge on the wrong lane, appears at the very next read of that word.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int REG_W = 32;
  localparam int NLANE = REG_W / 8;

  typedef enum logic [2:0] {
    RA_REQ    = 3'd0,
    RA_MASK   = 3'd1,
    RA_PEND   = 3'd2,
    RA_CTRL   = 3'd3,
    RA_TARGET = 3'd4
  } reg_addr_e;

  // big-endian byte lanes: strobe 0 covers the most significant byte
  function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] new_v,
                                                  input logic [NLANE-1:0] be);
    logic [REG_W-1:0] r;
    r = old_v;
    for (int b = 0; b < NLANE; b++)
      if (be[b]) r[REG_W-1-8*b -: 8] = new_v[REG_W-1-8*b -: 8];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] msg_addr_of(input logic [REG_W-1:0] t);
    return {t[REG_W-1:5], 5'b0};
  endfunction

  function automatic logic [REG_W-1:0] msg_data_of(input logic [REG_W-1:0] t);
    return {{(REG_W-5){1'b0}}, t[4:0]};
  endfunction
endpackage

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
  import irq_msg_pkg::*;
#(
  parameter int          NUM_SRC    = 28,
  parameter logic [31:0] TARGET_RST = 32'hFFFB_0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [2:0]         reg_addr,
  input  logic               reg_we,
  input  logic [NLANE-1:0]   reg_be,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               reg_re,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               mask_err,
  output logic [NUM_SRC-1:0] mask_src,
  output logic               ctrl_berr,
  output logic [REG_W-1:0]   target
);
  localparam logic [REG_W-1:0] IMPL = (NUM_SRC >= REG_W) ? '1 : ((REG_W'(1) << NUM_SRC) - 1);

  logic [NUM_SRC-1:0] req_q, pend_q;
  logic [REG_W-1:0]   mask_q, ctrl_q, tgt_q;
  logic [REG_W-1:0]   mask_merged, ctrl_merged, tgt_merged;
  logic               wr_mask, wr_ctrl, wr_tgt, pend_clr, mask_bad;
  logic [REG_W-1:0]   req_x, pend_x;

  assign wr_mask  = reg_we && reg_addr == RA_MASK;
  assign wr_ctrl  = reg_we && reg_addr == RA_CTRL;
  assign wr_tgt   = reg_we && reg_addr == RA_TARGET;
  assign pend_clr = (reg_we || reg_re) && reg_addr == RA_PEND;

  assign mask_merged = lane_merge(mask_q, reg_wdata, reg_be);
  assign ctrl_merged = lane_merge(ctrl_q, reg_wdata, reg_be);
  assign tgt_merged  = lane_merge(tgt_q,  reg_wdata, reg_be);
  assign mask_bad    = wr_mask && ((mask_merged & ~IMPL) != '0) && (mask_merged != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      pend_q   <= '0;
      mask_q   <= '0;
      ctrl_q   <= '0;
      tgt_q    <= TARGET_RST;
      mask_err <= 1'b0;
    end else begin
      req_q    <= req_q | (irq_in & mask_src);
      pend_q   <= (pend_clr ? '0 : pend_q) | irq_in;
      mask_err <= mask_bad;
      if (wr_mask) mask_q <= mask_merged;
      if (wr_ctrl) ctrl_q <= ctrl_merged;
      if (wr_tgt)  tgt_q  <= tgt_merged;
    end
  end

  always_comb begin
    req_x  = '0;
    pend_x = '0;
    req_x[NUM_SRC-1:0]  = req_q;
    pend_x[NUM_SRC-1:0] = pend_q;
    reg_rdata = '0;
    if (reg_re) begin
      case (reg_addr)
        RA_REQ:    reg_rdata = req_x;
        RA_MASK:   reg_rdata = mask_q;
        RA_PEND:   reg_rdata = pend_x;
        RA_CTRL:   reg_rdata = {{(REG_W-1){1'b0}}, ctrl_q[0]};
        RA_TARGET: reg_rdata = tgt_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign mask_src  = mask_q[NUM_SRC-1:0];
  assign ctrl_berr = ctrl_q[0];
  assign target    = tgt_q;

  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> pend_q == $past(irq_in));
  p_req_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_REQ) |=> req_q == ($past(req_q) | ($past(irq_in) & $past(mask_src))));
  p_allones_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && mask_merged == '1) |=> !mask_err);
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
  parameter int NUM_SRC = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] mask_src,
  input  logic               ctrl_berr,
  output logic [NUM_SRC-1:0] fire
);
  logic [NUM_SRC-1:0] hit, hit_q;

  assign hit  = irq_in & mask_src;
  assign fire = ctrl_berr ? '0 : (hit & ~hit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit;
  end

  p_no_repeat_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |=> ((fire & $past(fire)) == '0));
endmodule

// File: rtl/irq_send_queue.sv
module irq_send_queue #(
  parameter int NUM_SRC = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] fire,
  input  logic               msg_ready,
  output logic               msg_valid
);
  logic [NUM_SRC-1:0] flags_q, sel, clr;

  // one-hot of the lowest waiting source
  always_comb begin
    sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (flags_q[i]) sel = NUM_SRC'(1) << i;
  end

  assign msg_valid = |flags_q;
  assign clr       = (msg_valid && msg_ready) ? sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | fire;
  end

  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);
  p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |-> ($onehot(clr) && ((flags_q & (clr - NUM_SRC'(1))) == '0)));
  p_merge_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |=> ((flags_q & $past(fire)) == $past(fire)));
endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_msg_pkg::*;
#(
  parameter int          NUM_SRC    = 28,
  parameter logic [31:0] TARGET_RST = 32'hFFFB_0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [2:0]         reg_addr,
  input  logic               reg_we,
  input  logic [3:0]         reg_be,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_re,
  output logic [31:0]        reg_rdata,
  output logic               mask_err,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic [NUM_SRC-1:0] mask_src, fire;
  logic               ctrl_berr;
  logic [REG_W-1:0]   target;

  irq_msg_regs #(.NUM_SRC(NUM_SRC), .TARGET_RST(TARGET_RST)) u_regs (
    .clk, .rst_n, .irq_in, .reg_addr, .reg_we, .reg_be, .reg_wdata, .reg_re,
    .reg_rdata, .mask_err, .mask_src, .ctrl_berr, .target
  );

  irq_event_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk, .rst_n, .irq_in, .mask_src, .ctrl_berr, .fire
  );

  irq_send_queue #(.NUM_SRC(NUM_SRC)) u_queue (
    .clk, .rst_n, .fire, .msg_ready, .msg_valid
  );

  assign msg_addr = msg_addr_of(target);
  assign msg_data = msg_data_of(target);

  p_quiet_suppressed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_berr) && !$past(msg_valid)) |-> !msg_valid);
  p_stable_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !(reg_we && reg_addr == RA_TARGET)) |=> $stable(msg_addr) && $stable(msg_data));
endmodule

// File: tb/irq_msg_agg_test.sv
module irq_msg_agg_test;
  localparam int NS = 28;
  logic clk = 0, rst_n = 0;
  logic [NS-1:0] irq_in = '0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 0, reg_re = 0, msg_ready = 1;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, msg_addr, msg_data;
  logic mask_err, msg_valid;

  int checks = 0, errors = 0;
  logic [63:0] expq[$];
  logic [31:0] last_addr;

  irq_msg_agg uut (.clk, .rst_n, .irq_in, .reg_addr, .reg_we, .reg_be, .reg_wdata, .reg_re,
                   .reg_rdata, .mask_err, .msg_valid, .msg_ready, .msg_addr, .msg_data);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_msg(input logic [31:0] tgt);
    expq.push_back({tgt & 32'hFFFF_FFE0, 32'(tgt[4:0])});
  endtask

  // monitor: compares each accepted message with the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) chk(0, "R8 unexpected message", {msg_addr, msg_data}, 64'h0);
      else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk({msg_addr, msg_data} === e, "R6 message content", {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_addr = a; reg_we = 1; reg_wdata = d; reg_be = be;
    @(posedge clk); @(negedge clk);
    reg_we = 0; reg_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_re = 1; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
    @(posedge clk); @(negedge clk);
    reg_re = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] tgt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(msg_valid === 0, "R1 msg_valid", msg_valid, 0);
    chk(mask_err === 0, "R1 mask_err", mask_err, 0);
    rd(0, 0, "R1 request"); rd(1, 0, "R1 mask"); rd(2, 0, "R1 pending");
    rd(3, 0, "R1 control"); rd(4, 32'hFFFB_0003, "R1 target");
    // R12 unmapped words
    wr(5, 32'hDEAD_BEEF, 4'hF);
    rd(5, 0, "R12 unmapped read"); rd(4, 32'hFFFB_0003, "R12 target untouched");
    rd(1, 0, "R12 mask untouched");
    // R5 control reads bit 0 only
    wr(3, 32'hFFFF_FFFE, 4'hF);
    rd(3, 0, "R5 control upper bits hidden");
    // R11 big-endian lanes
    wr(1, 32'h0000_00AA, 4'b1000);
    rd(1, 32'h0000_00AA, "R11 lane3 low byte");
    wr(1, 32'h0F55_5555, 4'b0001);
    rd(1, 32'h0F00_00AA, "R11 lane0 high byte");
    // R10 mask error flag
    wr(1, 32'h1000_0001, 4'hF);
    chk(mask_err === 1, "R10 bad mask flag", mask_err, 1);
    @(negedge clk);
    chk(mask_err === 0, "R10 flag one cycle", mask_err, 0);
    rd(1, 32'h1000_0001, "R10 bad value stored");
    wr(1, 32'hFFFF_FFFF, 4'hF);
    chk(mask_err === 0, "R10 all ones accepted", mask_err, 0);
    wr(1, 32'h0000_0003, 4'hF);
    chk(mask_err === 0, "R10 legal mask", mask_err, 0);
    // R6 target
    tgt = 32'h1234_5677;
    wr(4, tgt, 4'hF);
    // R2 R8 enabled line held high: one message
    irq_in[0] = 1; push_msg(tgt);
    idle(3);
    irq_in[4] = 1;
    idle(2);
    irq_in = '0;
    idle(2);
    chk(expq.size() == 0, "R8 single message drained", expq.size(), 0);
    rd(2, 32'h11, "R2 pending both lines");
    rd(2, 0, "R3 pending cleared by read");
    rd(0, 32'h1, "R2 request enabled only");
    // R4 read-only request
    wr(0, 32'hFFFF_FFFF, 4'hF);
    rd(0, 32'h1, "R4 request write ignored");
    // R3 write clears pending
    irq_in[4] = 1; @(negedge clk); irq_in[4] = 0;
    wr(2, 32'h0, 4'h0);
    rd(2, 0, "R3 pending cleared by write");
    // R7 suppression
    wr(3, 32'h1, 4'hF);
    rd(3, 1, "R7 control bit 0 reads back");
    irq_in[1] = 1; idle(3);
    chk(msg_valid === 0, "R7 suppressed no message", msg_valid, 0);
    irq_in[1] = 0; idle(1);
    wr(3, 32'h0, 4'hF);
    idle(2);
    chk(msg_valid === 0, "R7 dropped event stays dropped", msg_valid, 0);
    // R9 queue with ready low
    wr(1, 32'hFF, 4'hF);
    tgt = 32'h8000_0040 | 32'h1E;
    wr(4, tgt, 4'hF);
    msg_ready = 0;
    irq_in[2] = 1; irq_in[5] = 1; irq_in[7] = 1;
    push_msg(tgt); push_msg(tgt); push_msg(tgt);
    idle(1);
    last_addr = msg_addr;
    idle(2);
    chk(msg_valid === 1, "R6 valid held without ready", msg_valid, 1);
    chk(msg_addr === last_addr, "R6 address stable", msg_addr, last_addr);
    irq_in[5] = 0; idle(1); irq_in[5] = 1; idle(1);  // merges into waiting flag
    msg_ready = 1;
    idle(6);
    chk(expq.size() == 0, "R9 all queued sent", expq.size(), 0);
    chk(msg_valid === 0, "R9 no extra message", msg_valid, 0);
    // R8 mask raised while line already high counts as one edge
    irq_in = '0; idle(1);
    wr(1, 32'h0, 4'hF);
    irq_in[3] = 1; idle(2);
    push_msg(tgt);
    wr(1, 32'h8, 4'hF);
    idle(4);
    chk(expq.size() == 0, "R8 enable edge delivered", expq.size(), 0);
    irq_in = '0;
    idle(2);
    chk(msg_valid === 0, "R8 idle at end", msg_valid, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule